// File: doc/BRIEF.md
# Ready/Valid FIFO Queue

This block is a first-in first-out buffer with a valid/ready handshake on each side. A producer offers a word on the input side and it is taken on any cycle where valid and ready are both high. A consumer takes the oldest stored word from the output side under the same rule. An occupancy output gives the number of words currently held.

Parameters set the word width and the number of entries. Four build options change the behaviour:
- A pass-through option lets a full queue take a new word in the same cycle that one leaves.
- A bypass option hands a word straight from input to output when the queue is empty.
- A storage option selects either a combinational read or a registered read of the entry array.
- A clear option adds a flush input that discards everything stored.

Full and empty are found by comparing the two wrapping pointers and looking at a one-bit flag that records whether the last unbalanced transfer was a write.

Top module: `rv_queue`

## Requirements
- R1: Words leave in the order they were accepted. A word is accepted when `in_valid` and `in_ready` are both high at a rising edge, and delivered when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low with words stored, `out_data` holds steady.
- R2: `level` equals the number of stored words, from 0 to DEPTH. While `rst_n` is low, `level` is 0 and `out_valid` is low. After reset the queue is empty.
- R3: With the pass-through option off, `in_ready` is low whenever `level` equals DEPTH, so a full queue never takes a word.
- R4: With the bypass option off, `out_valid` is low whenever `level` is 0.
- R5: With the pass-through option on (PIPE_EN=1), `in_ready` is high whenever `out_ready` is high, even when full. A one-entry queue therefore moves one word per cycle.
- R6: With the bypass option on (FLOW_EN=1) and `level` at 0, `out_valid` equals `in_valid` and `out_data` equals `in_data` in the same cycle. A word taken and delivered in that same cycle is never stored, so `level` stays 0.
- R7: With registered read (SYNC_READ=1), `out_data` carries the oldest stored word in every cycle where `out_valid` is high, exactly as with combinational read.
- R8: With the clear option on (FLUSH_EN=1), a rising edge with `flush_i` high leaves the queue empty. Stored words and any word offered in that cycle are dropped, and `level` reads 0 in the next cycle.
- R9: With the clear option off, `flush_i` has no effect on `level`, the handshakes or the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| flush_i | input | 1 | Discard all stored words (used only when FLUSH_EN=1) |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Queue can take a word this cycle |
| in_data | input | DATA_W | Word offered by the producer |
| out_valid | output | 1 | `out_data` holds a word for the consumer |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | DATA_W | Oldest word, or the input word when bypassing |
| level | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The bench builds five copies of the block side by side:
- Depth 4, every option off, and depth 1 with pass-through: these reach the plain full/empty limits and the single-entry full-rate case.
- Depth 3 with bypass and clear: reaches the empty-queue pass-through and the flush behaviour.
- Depth 5 with registered read, pass-through and clear: covers a depth that is not a power of two, where the pointers wrap short of their range and the read address has to run one cycle ahead.
- Depth 2 with registered read and bypass, at a 16-bit width: reaches the write-forward path of the registered read.

The copies with the clear option off still toggle the flush input, to show it is ignored.

// File: rtl/rvq_pkg.sv
`timescale 1ns/1ps
package rvq_pkg;

  // Occupancy class derived from pointer equality and the last-write flag
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_PART  = 2'd1,
    OCC_FULL  = 2'd2
  } occ_e;

  // Pointer width for a given depth (at least one bit)
  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/rvq_ptrs.sv
`timescale 1ns/1ps
module rvq_ptrs #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             enq_adv,
  input  logic             deq_adv,
  output logic [PTR_W-1:0] enq_ptr,
  output logic [PTR_W-1:0] deq_ptr,
  output logic [PTR_W-1:0] deq_nxt
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] enq_nxt;
  logic             enq_en;
  logic             deq_en;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  // next-state
  always_comb begin
    enq_en  = clr | enq_adv;
    deq_en  = clr | deq_adv;
    enq_nxt = clr ? '0 : (enq_adv ? bump(enq_ptr) : enq_ptr);
    deq_nxt = clr ? '0 : (deq_adv ? bump(deq_ptr) : deq_ptr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enq_ptr <= '0;
      deq_ptr <= '0;
    end else begin
      if (enq_en) enq_ptr <= enq_nxt;
      if (deq_en) deq_ptr <= deq_nxt;
    end
  end

endmodule

// File: rtl/rvq_store.sv
`timescale 1ns/1ps
module rvq_store #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4,
  parameter int PTR_W     = 2,
  parameter int SYNC_READ = 0
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  generate
    if (SYNC_READ != 0) begin : g_sync
      // rd_addr is the next-cycle head; forward a same-cycle write to it
      logic [DATA_W-1:0] rd_q;
      logic              fwd;
      assign fwd = wr_en && (wr_addr == rd_addr);
      always_ff @(posedge clk) begin
        if (fwd) rd_q <= wr_data;
        else     rd_q <= mem[rd_addr];
      end
      assign rd_data = rd_q;
    end else begin : g_comb
      assign rd_data = mem[rd_addr];
    end
  endgenerate

endmodule

// File: rtl/rvq_ctrl.sv
`timescale 1ns/1ps
module rvq_ctrl
  import rvq_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int PTR_W   = 2,
  parameter int CNT_W   = 3,
  parameter int PIPE_EN = 0,
  parameter int FLOW_EN = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [PTR_W-1:0] enq_ptr,
  input  logic [PTR_W-1:0] deq_ptr,
  output logic             in_ready,
  output logic             out_valid,
  output logic             bypass,
  output logic             do_enq,
  output logic             do_deq,
  output logic [CNT_W-1:0] level
);

  localparam bit PIPE = (PIPE_EN != 0);
  localparam bit FLOW = (FLOW_EN != 0);

  logic mfull_q;
  logic mfull_d;
  logic mfull_en;
  logic ptr_eq;
  logic in_fire;
  logic out_fire;
  occ_e occ;

  // occupancy class
  always_comb begin
    ptr_eq = (enq_ptr == deq_ptr);
    if (!ptr_eq)     occ = OCC_PART;
    else if (mfull_q) occ = OCC_FULL;
    else             occ = OCC_EMPTY;
  end

  // handshakes and transfer decisions
  always_comb begin
    bypass    = FLOW && (occ == OCC_EMPTY);
    in_ready  = rst_n && ((occ != OCC_FULL) || (PIPE && out_ready));
    out_valid = rst_n && ((occ != OCC_EMPTY) || (FLOW && in_valid));
    in_fire   = in_valid && in_ready;
    out_fire  = out_valid && out_ready;
    do_enq    = in_fire && !(bypass && out_ready);
    do_deq    = out_fire && !bypass;
  end

  // level from pointer distance
  always_comb begin
    unique case (occ)
      OCC_EMPTY: level = '0;
      OCC_FULL:  level = CNT_W'(DEPTH);
      default: begin
        if (enq_ptr > deq_ptr)
          level = CNT_W'(enq_ptr) - CNT_W'(deq_ptr);
        else
          level = CNT_W'(DEPTH) - (CNT_W'(deq_ptr) - CNT_W'(enq_ptr));
      end
    endcase
  end

  // last-write flag next-state
  always_comb begin
    mfull_en = flush || (do_enq != do_deq);
    mfull_d  = flush ? 1'b0 : do_enq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mfull_q <= 1'b0;
    end else if (mfull_en) begin
      mfull_q <= mfull_d;
    end
  end

endmodule

// File: rtl/rv_queue.sv
`timescale 1ns/1ps
module rv_queue #(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4,
  parameter int PIPE_EN   = 0,
  parameter int FLOW_EN   = 0,
  parameter int SYNC_READ = 0,
  parameter int FLUSH_EN  = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [DATA_W-1:0]            in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [DATA_W-1:0]            out_data,
  output logic [$clog2(DEPTH+1)-1:0]   level
);

  localparam int PTR_W = rvq_pkg::ptr_bits(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              flush_eff;
  logic              bypass;
  logic              do_enq;
  logic              do_deq;
  logic [PTR_W-1:0]  enq_ptr;
  logic [PTR_W-1:0]  deq_ptr;
  logic [PTR_W-1:0]  deq_nxt;
  logic [PTR_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  level_w;

  assign flush_eff = (FLUSH_EN != 0) && flush_i;

  rvq_ctrl #(
    .DEPTH   (DEPTH),
    .PTR_W   (PTR_W),
    .CNT_W   (CNT_W),
    .PIPE_EN (PIPE_EN),
    .FLOW_EN (FLOW_EN)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_eff),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .enq_ptr   (enq_ptr),
    .deq_ptr   (deq_ptr),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .bypass    (bypass),
    .do_enq    (do_enq),
    .do_deq    (do_deq),
    .level     (level_w)
  );

  rvq_ptrs #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
  ) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (flush_eff),
    .enq_adv (do_enq),
    .deq_adv (do_deq),
    .enq_ptr (enq_ptr),
    .deq_ptr (deq_ptr),
    .deq_nxt (deq_nxt)
  );

  // registered read needs the head address one cycle early
  assign rd_addr = (SYNC_READ != 0) ? deq_nxt : deq_ptr;

  rvq_store #(
    .DATA_W    (DATA_W),
    .DEPTH     (DEPTH),
    .PTR_W     (PTR_W),
    .SYNC_READ (SYNC_READ)
  ) u_store (
    .clk     (clk),
    .wr_en   (do_enq),
    .wr_addr (enq_ptr),
    .wr_data (in_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign out_data = bypass ? in_data : rd_data;
  assign level    = level_w;

endmodule

// File: rtl/rvq_chk.sv
`timescale 1ns/1ps
module rvq_chk #(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 4,
  parameter int PIPE_EN  = 0,
  parameter int FLOW_EN  = 0,
  parameter int FLUSH_EN = 0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flush_i,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [DATA_W-1:0]          in_data,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DATA_W-1:0]          out_data,
  input logic [$clog2(DEPTH+1)-1:0] level
);

  logic in_fire;
  logic out_fire;
  logic clr_now;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign clr_now  = (FLUSH_EN != 0) && flush_i;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) == DEPTH && in_fire) |-> out_fire); // R3

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH); // R2

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (FLOW_EN == 0 && level == '0) |-> !out_valid); // R4

  AST_PIPE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (PIPE_EN != 0 && out_ready) |-> in_ready); // R5

  AST_FLOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (FLOW_EN != 0 && level == '0) |-> (out_valid == in_valid && (!in_valid || out_data == in_data))); // R6

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_now |=> int'(level) == int'($past(level)) + int'($past(in_fire)) - int'($past(out_fire))); // R2 R9

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> level == '0); // R8

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && level != '0 && !clr_now) |=> (out_valid && $stable(out_data))); // R1

endmodule

bind rv_queue rvq_chk #(
  .DATA_W   (DATA_W),
  .DEPTH    (DEPTH),
  .PIPE_EN  (PIPE_EN),
  .FLOW_EN  (FLOW_EN),
  .FLUSH_EN (FLUSH_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_i   (flush_i),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .level     (level)
);

// File: tb/rv_queue_test.sv
`timescale 1ns/1ps
module rv_queue_lane #(
  parameter int          DATA_W    = 8,
  parameter int          DEPTH     = 4,
  parameter int          PIPE_EN   = 0,
  parameter int          FLOW_EN   = 0,
  parameter int          SYNC_READ = 0,
  parameter int          FLUSH_EN  = 0,
  parameter int unsigned SEED      = 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   nchk,
  output int   nfail
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              flush_i, in_valid, in_ready, out_valid, out_ready;
  logic [DATA_W-1:0] in_data, out_data;
  logic [CNT_W-1:0]  level;

  rv_queue #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PIPE_EN(PIPE_EN),
    .FLOW_EN(FLOW_EN), .SYNC_READ(SYNC_READ), .FLUSH_EN(FLUSH_EN)
  ) uut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .level(level)
  );

  // reference model state
  logic [DATA_W-1:0] mq [0:63];
  int head, cnt;
  bit prev_flush;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s depth=%0d %s: actual %0d expected %0d", tag, DEPTH, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [DATA_W-1:0] d, input bit r, input bit f);
    bit e_rdy, e_ov, en, de;
    logic [DATA_W-1:0] e_dat;
    string t;
    @(negedge clk);
    in_valid = v; in_data = d; out_ready = r; flush_i = f;
    #1;
    if (prev_flush) t = (FLUSH_EN != 0) ? "R8" : "R9";
    else            t = "R2";
    chk(int'(level) == cnt, t, "level", longint'(level), cnt);
    e_rdy = (cnt < DEPTH) || (PIPE_EN != 0 && r);
    e_ov  = (cnt > 0) || (FLOW_EN != 0 && v);
    e_dat = (cnt == 0) ? d : mq[head];
    if (cnt == DEPTH) t = (PIPE_EN != 0) ? "R5" : "R3";
    else              t = "R1";
    chk(in_ready == e_rdy, t, "in_ready", longint'(in_ready), longint'(e_rdy));
    if (cnt == 0) t = (FLOW_EN != 0) ? "R6" : "R4";
    else          t = "R1";
    chk(out_valid == e_ov, t, "out_valid", longint'(out_valid), longint'(e_ov));
    if (e_ov) begin
      if (cnt == 0)              t = "R6";
      else if (SYNC_READ != 0)   t = "R7";
      else                       t = "R1";
      chk(out_data == e_dat, t, "out_data", longint'(out_data), longint'(e_dat));
    end
    en = v && e_rdy;
    de = e_ov && r;
    if (FLUSH_EN != 0 && f) begin
      cnt = 0; head = 0;
    end else if (!(FLOW_EN != 0 && cnt == 0 && de)) begin
      if (de) begin head = (head + 1) % 64; cnt--; end
      if (en) begin mq[(head + cnt) % 64] = d; cnt++; end
    end
    prev_flush = f;
  endtask

  initial begin
    int pi, po;
    done = 0; nchk = 0; nfail = 0;
    head = 0; cnt = 0; prev_flush = 0;
    in_valid = 0; out_ready = 0; flush_i = 0; in_data = '0;
    void'($urandom(SEED));
    // R2: reset state
    while (!rst_n) begin
      @(negedge clk); #1;
      if (!rst_n) begin
        chk(out_valid == 1'b0, "R2", "out_valid in reset", longint'(out_valid), 0);
        chk(level == '0, "R2", "level in reset", longint'(level), 0);
      end
    end
    // fill past full (R3/R5), then drain past empty (R4/R6)
    repeat (DEPTH + 2) step(1'b1, DATA_W'($urandom), 1'b0, 1'b0);
    repeat (DEPTH + 2) step(1'b0, '0, 1'b1, 1'b0);
    // flush with stored words (R8 or R9)
    repeat (2) step(1'b1, DATA_W'($urandom), 1'b0, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b1, 1'b0);
    repeat (DEPTH + 1) step(1'b0, '0, 1'b1, 1'b0);
    // random phases with varied pressure
    for (int ph = 0; ph < 6; ph++) begin
      case (ph % 3)
        0: begin pi = 90; po = 25; end
        1: begin pi = 25; po = 90; end
        default: begin pi = 65; po = 65; end
      endcase
      if (ph >= 3) po = 100 - po / 2;
      repeat (100)
        step(($urandom % 100) < pi, DATA_W'($urandom), ($urandom % 100) < po, ($urandom % 40) == 0);
    end
    repeat (DEPTH + 2) step(1'b0, '0, 1'b1, 1'b0);
    done = 1;
  end

endmodule

module rv_queue_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] dn;
  int         lane_chk [5];
  int         lane_bad [5];

  always #2.5 clk = ~clk;

  rv_queue_lane #(.DATA_W(8),  .DEPTH(4), .SEED(11)) l_plain
    (.clk(clk), .rst_n(rst_n), .done(dn[0]), .nchk(lane_chk[0]), .nfail(lane_bad[0]));
  rv_queue_lane #(.DATA_W(8),  .DEPTH(1), .PIPE_EN(1), .SEED(22)) l_pipe
    (.clk(clk), .rst_n(rst_n), .done(dn[1]), .nchk(lane_chk[1]), .nfail(lane_bad[1]));
  rv_queue_lane #(.DATA_W(8),  .DEPTH(3), .FLOW_EN(1), .FLUSH_EN(1), .SEED(33)) l_flow
    (.clk(clk), .rst_n(rst_n), .done(dn[2]), .nchk(lane_chk[2]), .nfail(lane_bad[2]));
  rv_queue_lane #(.DATA_W(8),  .DEPTH(5), .PIPE_EN(1), .SYNC_READ(1), .FLUSH_EN(1), .SEED(44)) l_sync
    (.clk(clk), .rst_n(rst_n), .done(dn[3]), .nchk(lane_chk[3]), .nfail(lane_bad[3]));
  rv_queue_lane #(.DATA_W(16), .DEPTH(2), .FLOW_EN(1), .SYNC_READ(1), .SEED(55)) l_fwd
    (.clk(clk), .rst_n(rst_n), .done(dn[4]), .nchk(lane_chk[4]), .nfail(lane_bad[4]));

  initial begin
    int cyc, tot, bad;
    cyc = 0; tot = 0; bad = 0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    while (dn != 5'h1f && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    for (int i = 0; i < 5; i++) begin
      tot += lane_chk[i];
      bad += lane_bad[i];
    end
    if (dn != 5'h1f) begin
      tot++; bad++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion below %0d", cyc, 100000);
    end
    $display("  [TB] %0d tests run, %0d failed", tot, bad);
    $finish;
  end

endmodule